// File: doc/BRIEF.md
# Three-Frame Serial Line to Parallel Output Decoder

The block turns an asynchronous serial line into three latched output bits without a full UART. Each 8N1 character that a host transmits is read as three short frames. Each frame is a low start level, one data cell and one stop cell. The host places its three output values at character bits 0, 3 and 6. It keeps bits 1 and 4 high and bit 7 low, so the base pattern is 0x12. The deliberately low stop bit of the third frame is a framing violation. The decoder uses it to bring its frame counter back to the first position, so the decoder resynchronises on every character.

A falling edge on the synchronised line starts one timer. The timer samples the line at 1.5 bit periods, which is the centre of the data cell. It samples again at 2.5 bit periods, which is the centre of the stop cell. The data sample goes into the output latch that the frame counter selects. A high stop sample advances the counter and a low one clears it. The bit period is a parameter in system clock cycles and must be at least 4. A build-time mode can force output 1 set or clear whenever a low stop bit is seen. This lets output 1 act as a bit-banged serial clock that returns to a fixed level at the end of every character.

Top module: `tri_frame_decoder`

## Requirements
- R1: While rst_ni is low, all three outputs are 0 and the frame counter is at the first position. The first frame after reset writes output 0.
- R2: The data cell is sampled once, 1.5 bit periods after the start edge. Line activity elsewhere in the data cell does not change the latched value.
- R3: The stop cell is sampled 2.5 bit periods after the start edge. A low level there returns the counter to the first position, whatever the line does elsewhere in that cell.
- R4: The frame counter steers data. The first, second and third frames write outputs 0, 1 and 2 in turn. For a character 0x12 OR w0·0x01 OR w1·0x08 OR w2·0x40, the result is dout_o = {w2,w1,w0}.
- R5: An output changes only when its own frame position is received, or through the forcing of R9. Otherwise it holds its value.
- R6: Sending 0x00 or 0x80 from any counter position writes 0 to the currently selected output and then resets the counter. The next normal character then lands correctly aligned.
- R7: A third frame whose stop bit is high wraps the counter to the first position.
- R8: Falling edges that occur while the timer runs, from the start edge up to the stop sample, are ignored and do not start a new frame.
- R9: Output 1 is forced by the D1_MODE parameter on every low stop sample. Encoding 0 (keep) leaves it alone, encoding 1 (clear) drives it to 0 and encoding 2 (set) drives it to 1.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| dout_o | output | 3 | Latched frame data bits, index = frame position |

## Verification
A frame counter out of step shows at the ports within one character. A normal character then puts its data bits into rotated output positions, or leaves one output stale. A timer that restarts on a stray edge, or samples at the wrong offset, shows as a wrong value on the next output written, about two bit periods after the start edge. The stimulus therefore includes cells that carry the wrong level outside their centre, lone frames that walk the counter through all three positions, and resynchronising characters sent from a misaligned state.

// File: rtl/tfd_pkg.sv
package tfd_pkg;
  typedef enum logic [1:0] {
    D1_KEEP  = 2'd0,
    D1_CLEAR = 2'd1,
    D1_SET   = 2'd2
  } d1_mode_e;

  localparam int unsigned N_FRAMES = 3;
  typedef logic [1:0] frame_idx_t;
endpackage

// File: rtl/tfd_sync.sv
module tfd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic line_o,
  output logic fall_o
);
  logic [STAGES-1:0] sr_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '1;
      prev_q <= 1'b1;
    end else begin
      sr_q   <= {sr_q[STAGES-2:0], rx_i};
      prev_q <= sr_q[STAGES-1];
    end
  end

  assign line_o = sr_q[STAGES-1];
  assign fall_o = prev_q & ~sr_q[STAGES-1];
endmodule

// File: rtl/tfd_timer.sv
module tfd_timer #(
  parameter int unsigned BIT_CYC = 16,
  localparam int unsigned MID_C  = (3 * BIT_CYC) / 2 - 1,
  localparam int unsigned STOP_C = (5 * BIT_CYC) / 2 - 1,
  localparam int unsigned CNT_W  = $clog2(STOP_C + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fall_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             data_stb_o,
  output logic             stop_stb_o
);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic             at_stop;

  assign at_stop = (cnt_q == CNT_W'(STOP_C));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      cnt_q <= '0;
      if (fall_i) busy_q <= 1'b1;  // new edges only accepted when idle
    end else if (at_stop) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy_o     = busy_q;
  assign cnt_o      = cnt_q;
  assign data_stb_o = busy_q && (cnt_q == CNT_W'(MID_C));
  assign stop_stb_o = busy_q && at_stop;
endmodule

// File: rtl/tfd_steer.sv
module tfd_steer
  import tfd_pkg::*;
#(
  parameter d1_mode_e D1_MODE = D1_KEEP
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                line_i,
  input  logic                data_stb_i,
  input  logic                stop_stb_i,
  output logic [N_FRAMES-1:0] dout_o,
  output frame_idx_t          frame_o
);
  frame_idx_t frame_q;
  logic       viol;

  assign viol = stop_stb_i & ~line_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '0;
    end else if (stop_stb_i) begin
      if (!line_i) frame_q <= '0;
      else if (frame_q == frame_idx_t'(N_FRAMES - 1)) frame_q <= '0;
      else frame_q <= frame_q + 1'b1;
    end
  end

  for (genvar g = 0; g < N_FRAMES; g++) begin : g_lat
    logic q;
    if (g == 1 && D1_MODE != D1_KEEP) begin : g_forced
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= 1'b0;
        else if (viol) q <= (D1_MODE == D1_SET);
        else if (data_stb_i && frame_q == frame_idx_t'(g)) q <= line_i;
      end
    end else begin : g_plain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= 1'b0;
        else if (data_stb_i && frame_q == frame_idx_t'(g)) q <= line_i;
      end
    end
    assign dout_o[g] = q;
  end

  assign frame_o = frame_q;
endmodule

// File: rtl/tri_frame_decoder.sv
module tri_frame_decoder
  import tfd_pkg::*;
#(
  parameter int unsigned BIT_CYC     = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter d1_mode_e    D1_MODE     = D1_KEEP,
  localparam int unsigned STOP_C = (5 * BIT_CYC) / 2 - 1,
  localparam int unsigned CNT_W  = $clog2(STOP_C + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_i,
  output logic [2:0] dout_o
);
  logic             line;
  logic             fall;
  logic             busy;
  logic [CNT_W-1:0] tcnt;
  logic             data_stb;
  logic             stop_stb;
  frame_idx_t       frame;

  tfd_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rx_i  (rx_i),
    .line_o(line),
    .fall_o(fall)
  );

  tfd_timer #(.BIT_CYC(BIT_CYC)) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fall_i    (fall),
    .busy_o    (busy),
    .cnt_o     (tcnt),
    .data_stb_o(data_stb),
    .stop_stb_o(stop_stb)
  );

  tfd_steer #(.D1_MODE(D1_MODE)) i_steer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .line_i    (line),
    .data_stb_i(data_stb),
    .stop_stb_i(stop_stb),
    .dout_o    (dout_o),
    .frame_o   (frame)
  );
endmodule

// File: rtl/tri_frame_decoder_chk.sv
module tri_frame_decoder_chk
  import tfd_pkg::*;
#(
  parameter int unsigned BIT_CYC = 16,
  parameter d1_mode_e    D1_MODE = D1_KEEP,
  localparam int unsigned STOP_C = (5 * BIT_CYC) / 2 - 1,
  localparam int unsigned CNT_W  = $clog2(STOP_C + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             line,
  input logic             fall,
  input logic             busy,
  input logic [CNT_W-1:0] tcnt,
  input logic             stop_stb,
  input frame_idx_t       frame,
  input logic [2:0]       dout_o
);
  localparam bit MODE_SET = (D1_MODE == D1_SET);
  localparam bit MODE_CLR = (D1_MODE == D1_CLEAR);

  AST_RESET_LOW: assert property (@(posedge clk_i)
    !rst_ni |-> (dout_o == 3'b000 && frame == 2'd0));  // R1

  AST_FRAME_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame != 2'd3);  // R4

  AST_ONE_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(dout_o ^ $past(dout_o)) <= 1);  // R5

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |=> $stable(dout_o));  // R5

  AST_VIOL_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_stb && !line) |=> (frame == 2'd0));  // R3

  AST_EDGE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && fall && tcnt != CNT_W'(STOP_C)) |=> (busy && tcnt == $past(tcnt) + 1'b1));  // R8

  AST_FORCE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (MODE_SET && stop_stb && !line) |=> dout_o[1]);  // R9

  AST_FORCE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (MODE_CLR && stop_stb && !line) |=> !dout_o[1]);  // R9
endmodule

bind tri_frame_decoder tri_frame_decoder_chk #(
  .BIT_CYC(BIT_CYC),
  .D1_MODE(D1_MODE)
) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .line    (line),
  .fall    (fall),
  .busy    (busy),
  .tcnt    (tcnt),
  .stop_stb(stop_stb),
  .frame   (frame),
  .dout_o  (dout_o)
);

// File: tb/test_tri_frame_decoder.sv
module test_tri_frame_decoder;
  import tfd_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int BIT        = 16;
  localparam int N_VEC      = 10;

  typedef struct packed {
    logic [7:0] ch;
    logic [2:0] exp;
  } vec_t;

  // every entry has a low stop bit somewhere, so set/clear instances force dout[1]
  localparam vec_t VECS [N_VEC] = '{
    '{8'h53, 3'b101}, '{8'h1A, 3'b010}, '{8'h5B, 3'b111}, '{8'h12, 3'b000},
    '{8'h1B, 3'b011}, '{8'h52, 3'b100}, '{8'h81, 3'b101}, '{8'h00, 3'b100},
    '{8'h5B, 3'b111}, '{8'h80, 3'b110}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic [2:0] dout_keep, dout_set, dout_clr;
  int         n_chk = 0;
  int         n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tri_frame_decoder #(.BIT_CYC(BIT), .D1_MODE(D1_KEEP)) i_tri_frame_decoder (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .dout_o(dout_keep));
  tri_frame_decoder #(.BIT_CYC(BIT), .D1_MODE(D1_SET)) i_tri_frame_decoder_set (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .dout_o(dout_set));
  tri_frame_decoder #(.BIT_CYC(BIT), .D1_MODE(D1_CLEAR)) i_tri_frame_decoder_clr (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .dout_o(dout_clr));

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: dout=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic lvl, input int cyc);
    rx = lvl;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] ch);
    drive(1'b0, BIT);
    for (int i = 0; i < 8; i++) drive(ch[i], BIT);
    drive(1'b1, BIT);
    drive(1'b1, 2 * BIT);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset keep", dout_keep, 3'b000);
    chk("R1 reset set", dout_set, 3'b000);
    chk("R1 reset clr", dout_clr, 3'b000);
    rst_n = 1'b1;
    drive(1'b1, 4 * BIT);

    // R4 R5 R6 R9: table walk
    for (int v = 0; v < N_VEC; v++) begin
      send_char(VECS[v].ch);
      chk("R4/R5/R6 keep", dout_keep, VECS[v].exp);
      chk("R9 set", dout_set, VECS[v].exp | 3'b010);
      chk("R9 clr", dout_clr, VECS[v].exp & 3'b101);
    end

    send_char(8'h12);
    chk("R4 base char", dout_keep, 3'b000);

    // R2 R8: data cell wrong outside its centre, stray fall late in cell
    drive(1'b0, BIT);
    drive(1'b0, 4);
    drive(1'b1, BIT - 6);
    drive(1'b0, 2);
    drive(1'b1, BIT);
    drive(1'b1, 8 * BIT);
    chk("R2/R8 centre sample, stray edge", dout_keep, 3'b001);

    // R4 R7: lone frames walk the counter
    send_char(8'hFF);
    chk("R4 second frame", dout_keep, 3'b011);
    send_char(8'hFF);
    chk("R4 third frame", dout_keep, 3'b111);
    send_char(8'hFE);
    chk("R7 wrap to first", dout_keep, 3'b110);

    // R6: resync from misaligned counter
    send_char(8'h80);
    chk("R6 0x80 misaligned", dout_keep, 3'b100);
    send_char(8'h5B);
    chk("R6 aligned after 0x80", dout_keep, 3'b111);
    send_char(8'hFE);
    chk("R6 misalign step", dout_keep, 3'b110);
    send_char(8'h00);
    chk("R6 0x00 misaligned", dout_keep, 3'b100);
    send_char(8'h53);
    chk("R6 aligned after 0x00", dout_keep, 3'b101);

    // R1: reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 mid reset keep", dout_keep, 3'b000);
    chk("R1 mid reset set", dout_set, 3'b000);
    chk("R1 mid reset clr", dout_clr, 3'b000);
    rst_n = 1'b1;
    drive(1'b1, 2 * BIT);
    send_char(8'hFF);
    chk("R1 first frame to out0", dout_keep, 3'b001);

    // R3: stop cell low only at its centre resets the counter
    drive(1'b0, BIT);
    drive(1'b0, BIT);
    drive(1'b1, 4);
    drive(1'b0, BIT - 6);
    drive(1'b1, 2);
    drive(1'b1, 8 * BIT);
    chk("R3 centre-low stop", dout_keep, 3'b001);
    send_char(8'hFE);
    chk("R3 counter back to first", dout_keep, 3'b000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule